// File: doc/BRIEF.md
# Single-Wire Pulse-Width Bit Receiver

This block turns the traffic on an idle-high, open-drain, single-wire line into bytes. The line carries one bit per cell, and every cell opens with a falling edge. The width of the low phase encodes the bit. A short low phase followed by a long high phase is a 1, and a long low phase followed by a short high phase is a 0. Nominal cells are 4 µs long, and the short phase is about 1 µs.

The receiver has no shared clock with the sender. The line input first passes through a synchronizer. Each falling edge then starts a local timer, and the line level is read once, a fixed delay later, in the middle of the cell. Because every cell re-aligns on its own edge, timing drift does not build up from one bit to the next. Bits are gathered MSB first, and each complete byte is presented with a single-cycle strobe.

A long silence after the last rising edge closes the frame and raises a one-cycle done pulse. Any bits left over from an unfinished byte are then discarded, which includes the trailing stop pulse.

Top module: `pw_bit_rx`

## Requirements
- R1: While reset is asserted and in the first cycles after it, byte_valid_o and frame_done_o are 0 and byte_data_o is 0x00.
- R2: A falling edge on line_i opens a cell. The synchronized level SAMPLE_CYC cycles after that edge decides the bit: high gives 1 and low gives 0. With the defaults at 200 MHz, this is 400 cycles (2 µs), and a cell is 800 cycles.
- R3: Bits are shifted in MSB first, so the first bit of a byte lands in byte_data_o[7]. After every eighth bit, byte_valid_o is high for exactly one cycle, and byte_data_o changes only in that cycle.
- R4: The bit value stays correct when the low phase of each cell and the cell length each vary by up to ±300 ns (±60 cycles).
- R5: frame_done_o pulses for one cycle once the line has stayed high for TIMEOUT_CYC cycles after its last rising edge (1600 cycles, 8 µs). A high gap inside a frame that is shorter than this (for example 6 µs) raises no pulse.
- R6: At frame end, every bit of an unfinished byte, including the stop pulse, is dropped. No byte is emitted for them, and the next frame starts at bit 7 of a fresh byte. byte_valid_o and frame_done_o are never high together.
- R7: A falling edge that arrives while a cell is still waiting for its sample point is ignored. Each cell gives exactly one sample, and successive samples are at least SAMPLE_CYC cycles apart.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Receiver clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| line_i | input | 1 | Asynchronous level of the single-wire line |
| byte_valid_o | output | 1 | One-cycle strobe marking a completed byte |
| byte_data_o | output | 8 | Last completed byte, first received bit in bit 7 |
| frame_done_o | output | 1 | One-cycle pulse at the end of a frame |

## Verification
The assertions assume a well-formed line. Every low phase ends clearly before or clearly after the sample point, and no cell is shorter than the sample delay. They also assume that gaps inside a frame stay below the timeout, so a byte strobe and a frame-end pulse can never meet. The stimulus keeps jitter to ±60 cycles around phases of 200 and 600 cycles, so the sample point at 400 always has a margin of at least 140 cycles. Glitches are placed only inside the waiting window, well away from the sample point. Every frame ends with at least 2000 idle cycles, which is more than the 1600-cycle timeout.

// File: rtl/pw_rx_pkg.sv
package pw_rx_pkg;
  localparam int unsigned BYTE_W = 8;
  localparam int unsigned BCNT_W = $clog2(BYTE_W);
  typedef logic [BYTE_W-1:0] byte_t;
  typedef struct packed {
    logic stb;
    logic val;
  } smp_t;
endpackage

// File: rtl/pw_line_sync.sv
module pw_line_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic line_i,
  output logic lvl_o,
  output logic fall_o,
  output logic rise_o
);
  // [STAGES-1:0] synchronizer, top bit holds previous level
  logic [STAGES:0] chain_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) chain_q <= '1;
    else         chain_q <= {chain_q[STAGES-1:0], line_i};
  end

  assign lvl_o  = chain_q[STAGES-1];
  assign fall_o = chain_q[STAGES] & ~chain_q[STAGES-1];
  assign rise_o = ~chain_q[STAGES] & chain_q[STAGES-1];
endmodule

// File: rtl/pw_cell_timer.sv
module pw_cell_timer
  import pw_rx_pkg::*;
#(
  parameter int unsigned SAMPLE_CYC = 400
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic fall_i,
  output smp_t smp_o
);
  localparam int unsigned CW = $clog2(SAMPLE_CYC + 1);

  logic          busy_q;
  logic [CW-1:0] cnt_q;
  smp_t          smp_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      busy_q <= 1'b0;
      cnt_q  <= '0;
      smp_q  <= '0;
    end else begin
      smp_q.stb <= 1'b0;
      if (!busy_q) begin
        if (fall_i) begin
          busy_q <= 1'b1;
          cnt_q  <= CW'(1);
        end
      end else if (cnt_q == CW'(SAMPLE_CYC)) begin
        busy_q <= 1'b0;
        smp_q  <= '{stb: 1'b1, val: lvl_i};
      end else begin
        cnt_q <= cnt_q + CW'(1);
      end
    end
  end

  assign smp_o = smp_q;
endmodule

// File: rtl/pw_byte_asm.sv
module pw_byte_asm
  import pw_rx_pkg::*;
(
  input  logic  clk_i,
  input  logic  rst_ni,
  input  smp_t  smp_i,
  input  logic  flush_i,
  output logic  valid_o,
  output byte_t data_o
);
  logic [BCNT_W-1:0] bcnt_q;
  byte_t             sh_q;
  byte_t             data_q;
  logic              valid_q;
  byte_t             nxt;
  logic              last;

  assign nxt  = {sh_q[BYTE_W-2:0], smp_i.val};
  assign last = (bcnt_q == BCNT_W'(BYTE_W - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      bcnt_q  <= '0;
      sh_q    <= '0;
      data_q  <= '0;
      valid_q <= 1'b0;
    end else begin
      valid_q <= 1'b0;
      if (flush_i) begin
        bcnt_q <= '0;
      end else if (smp_i.stb) begin
        sh_q   <= nxt;
        bcnt_q <= last ? '0 : bcnt_q + BCNT_W'(1);
        if (last) begin
          data_q  <= nxt;
          valid_q <= 1'b1;
        end
      end
    end
  end

  assign valid_o = valid_q;
  assign data_o  = data_q;
endmodule

// File: rtl/pw_frame_end.sv
module pw_frame_end #(
  parameter int unsigned TIMEOUT_CYC = 1600
) (
  input  logic clk_i,
  input  logic rst_ni,
  input  logic lvl_i,
  input  logic fall_i,
  input  logic rise_i,
  output logic done_o
);
  localparam int unsigned CW = $clog2(TIMEOUT_CYC + 1);

  logic          armed_q;
  logic          done_q;
  logic [CW-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      armed_q <= 1'b0;
      done_q  <= 1'b0;
      cnt_q   <= '0;
    end else begin
      done_q <= 1'b0;
      if (fall_i) begin
        armed_q <= 1'b0;
      end else if (rise_i) begin
        armed_q <= 1'b1;
        cnt_q   <= '0;
      end else if (armed_q && lvl_i) begin
        if (cnt_q == CW'(TIMEOUT_CYC - 1)) begin
          armed_q <= 1'b0;
          done_q  <= 1'b1;
        end else begin
          cnt_q <= cnt_q + CW'(1);
        end
      end
    end
  end

  assign done_o = done_q;
endmodule

// File: rtl/pw_bit_rx.sv
module pw_bit_rx
  import pw_rx_pkg::*;
#(
  parameter int unsigned SYNC_STAGES = 2,
  parameter int unsigned SAMPLE_CYC  = 400,
  parameter int unsigned TIMEOUT_CYC = 1600
) (
  input  logic        clk_i,
  input  logic        rst_ni,
  input  logic        line_i,
  output logic        byte_valid_o,
  output logic [7:0]  byte_data_o,
  output logic        frame_done_o
);
  logic  lvl, fall, rise, done;
  smp_t  smp;
  logic  samp_stb;
  byte_t data;

  pw_line_sync #(.STAGES(SYNC_STAGES)) u_sync (
    .clk_i (clk_i), .rst_ni(rst_ni), .line_i(line_i),
    .lvl_o (lvl),   .fall_o(fall),   .rise_o(rise)
  );

  pw_cell_timer #(.SAMPLE_CYC(SAMPLE_CYC)) u_cell (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .fall_i(fall), .smp_o(smp)
  );

  pw_byte_asm u_asm (
    .clk_i(clk_i), .rst_ni(rst_ni), .smp_i(smp), .flush_i(done),
    .valid_o(byte_valid_o), .data_o(data)
  );

  pw_frame_end #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_fend (
    .clk_i(clk_i), .rst_ni(rst_ni), .lvl_i(lvl), .fall_i(fall),
    .rise_i(rise), .done_o(done)
  );

  assign samp_stb     = smp.stb;
  assign byte_data_o  = data;
  assign frame_done_o = done;
endmodule

// File: rtl/pw_bit_rx_chk.sv
module pw_bit_rx_chk #(
  parameter int unsigned SAMPLE_CYC = 400
) (
  input logic       clk_i,
  input logic       rst_ni,
  input logic       byte_valid_o,
  input logic [7:0] byte_data_o,
  input logic       frame_done_o,
  input logic       samp_stb_i
);
  localparam int unsigned GW = $clog2(SAMPLE_CYC + 2);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)         gap_q <= GW'(SAMPLE_CYC);
    else if (samp_stb_i) gap_q <= GW'(1);
    else if (gap_q < GW'(SAMPLE_CYC)) gap_q <= gap_q + GW'(1);
  end

  AST_VALID_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    byte_valid_o |=> !byte_valid_o); // R3
  AST_DATA_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !byte_valid_o |-> $stable(byte_data_o)); // R3
  AST_DONE_PULSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_done_o |=> !frame_done_o); // R5
  AST_NO_VALID_AT_END: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(byte_valid_o && frame_done_o)); // R6
  AST_SAMPLE_SPACING: assert property (@(posedge clk_i) disable iff (!rst_ni)
    samp_stb_i |-> gap_q >= GW'(SAMPLE_CYC)); // R7
endmodule

bind pw_bit_rx pw_bit_rx_chk #(.SAMPLE_CYC(SAMPLE_CYC)) u_chk (
  .clk_i(clk_i), .rst_ni(rst_ni), .byte_valid_o(byte_valid_o),
  .byte_data_o(byte_data_o), .frame_done_o(frame_done_o),
  .samp_stb_i(samp_stb)
);

// File: tb/pw_bit_rx_bench.sv
`timescale 1ns/1ps
module pw_bit_rx_bench;
  localparam int CELL = 800;
  localparam int LOW1 = 200;
  localparam int LOW0 = 600;

  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       line_i = 1'b1;
  logic       byte_valid_o;
  logic [7:0] byte_data_o;
  logic       frame_done_o;

  int n_chk = 0, n_bad = 0;
  int n_got = 0, n_done = 0, pulse_err = 0;
  logic [7:0] got [0:15];
  logic prev_v = 1'b0, prev_d = 1'b0;
  bit finished = 1'b0;

  always #2.5 clk_i = ~clk_i;

  pw_bit_rx u_pw_bit_rx (
    .clk_i(clk_i), .rst_ni(rst_ni), .line_i(line_i),
    .byte_valid_o(byte_valid_o), .byte_data_o(byte_data_o),
    .frame_done_o(frame_done_o)
  );

  always @(negedge clk_i) begin
    if (rst_ni) begin
      if (byte_valid_o) begin
        if (n_got < 16) got[n_got] = byte_data_o;
        n_got++;
      end
      if (frame_done_o) n_done++;
      if ((byte_valid_o && prev_v) || (frame_done_o && prev_d)) pulse_err++;
      prev_v = byte_valid_o;
      prev_d = frame_done_o;
    end
  end

  task automatic chk(string req, int act, int exp);
    n_chk++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic hold(logic v, int n);
    line_i = v;
    repeat (n) @(negedge clk_i);
  endtask

  task automatic send_bit(logic b, int jl, int jc);
    int lo;
    lo = (b ? LOW1 : LOW0) + jl;
    hold(1'b0, lo);
    hold(1'b1, CELL + jc - lo);
  endtask

  task automatic send_byte(logic [7:0] v, int jit);
    for (int i = 7; i >= 0; i--)
      send_bit(v[i], (i % 2) ? jit : -jit, (i % 3 == 0) ? jit : -jit);
  endtask

  task automatic end_frame();
    hold(1'b0, LOW1);
    hold(1'b1, 2000);
  endtask

  task automatic clear_log();
    n_got = 0;
    n_done = 0;
  endtask

  task automatic t_reset();
    chk("R1 valid", int'(byte_valid_o), 0);
    chk("R1 done", int'(frame_done_o), 0);
    chk("R1 data", int'(byte_data_o), 0);
  endtask

  task automatic t_single();
    clear_log();
    send_byte(8'hA5, 0);
    end_frame();
    chk("R2 value", int'(got[0]), 8'hA5);
    chk("R6 byte count", n_got, 1);
    chk("R5 frame done", n_done, 1);
  endtask

  task automatic t_msb();
    clear_log();
    send_byte(8'h80, 0);
    send_byte(8'h01, 0);
    end_frame();
    chk("R3 count", n_got, 2);
    chk("R3 msb first", int'(got[0]), 8'h80);
    chk("R3 lsb last", int'(got[1]), 8'h01);
  endtask

  task automatic t_jitter();
    clear_log();
    send_byte(8'h00, 60);
    send_byte(8'hFF, -60);
    send_byte(8'h3C, 60);
    end_frame();
    chk("R4 count", n_got, 3);
    chk("R4 byte0", int'(got[0]), 8'h00);
    chk("R4 byte1", int'(got[1]), 8'hFF);
    chk("R4 byte2", int'(got[2]), 8'h3C);
    chk("R4 done", n_done, 1);
  endtask

  task automatic t_glitch();
    logic [7:0] v;
    v = 8'hC3;
    clear_log();
    for (int i = 7; i >= 0; i--) begin
      if (v[i]) begin
        hold(1'b0, 200); hold(1'b1, 80); hold(1'b0, 20); hold(1'b1, 500);
      end else begin
        hold(1'b0, 150); hold(1'b1, 20); hold(1'b0, 430); hold(1'b1, 200);
      end
    end
    end_frame();
    chk("R7 count", n_got, 1);
    chk("R7 value", int'(got[0]), 8'hC3);
  endtask

  task automatic t_partial();
    clear_log();
    send_bit(1'b1, 0, 0); send_bit(1'b0, 0, 0);
    send_bit(1'b1, 0, 0); send_bit(1'b0, 0, 0);
    end_frame();
    chk("R6 no partial byte", n_got, 0);
    chk("R6 done", n_done, 1);
    clear_log();
    send_byte(8'h5A, 0);
    end_frame();
    chk("R6 realigned count", n_got, 1);
    chk("R6 realigned value", int'(got[0]), 8'h5A);
  endtask

  task automatic t_gap();
    clear_log();
    send_byte(8'h12, 0);
    hold(1'b1, 1200);
    send_byte(8'h34, 0);
    chk("R5 no early done", n_done, 0);
    end_frame();
    chk("R5 one done", n_done, 1);
    chk("R5 byte0", int'(got[0]), 8'h12);
    chk("R5 byte1", int'(got[1]), 8'h34);
  endtask

  initial begin
    repeat (4) @(negedge clk_i);
    t_reset();
    rst_ni = 1'b1;
    repeat (4) @(negedge clk_i);
    t_reset();
    t_single();
    t_msb();
    t_jitter();
    t_glitch();
    t_partial();
    t_gap();
    chk("R3 R5 pulse width", pulse_err, 0);
    finished = 1'b1;
    $display("test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk_i);
    if (!finished) begin
      n_chk++;
      n_bad++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("test done: total=%0d bad=%0d", n_chk, n_bad);
      $finish;
    end
  end
endmodule